// File: doc/BRIEF.md
# Motor Drive Mode Supervisor with Stall Guard

This block sits between a quantised control-level input and the gate-drive logic of a three-phase bridge. The control level selects one of four operating levels: power-save, standby, drive or test. From it the block derives per-bank permissions for the high-side and low-side gates, a low-side force used for bootstrap charging, a Hall-sensor bias enable, a hold on the speed pulse outputs and a force for test conduction. The commutation and PWM logic downstream combines these permissions with its own phase pattern.

On the first entry to drive after power-save, the block runs a timed bootstrap precharge before it releases normal drive. In standby it emits short periodic low-side charge pulses. Active-low external fault and overtemperature inputs block every gate while they are asserted. An undervoltage flag parks the block in a lockout state, and when the flag clears the block re-enters through standby.

A stall guard watches the three Hall lines during drive. If they hold one code for a set number of cycles, it withdraws the high-side permission. It recovers by itself after a hold-off of the same length. Power-save clears it, and thermal shutdown freezes its count.

Top module: `motor_mode_supervisor`

## Requirements
- R1: After reset, and whenever the level input is 0 (power-save), all three gate controls are low, the Hall bias enable is low and the speed hold output is high.
- R2: In standby (level 1), the high-side permission is low and the low-side force is high for PULSE_W cycles out of every PULSE_PERIOD cycles.
- R3: When the level goes from power-save through standby to drive (level 2), the low-side force stays high with the high-side permission low for exactly BOOT_CYC cycles. After that, both bank permissions go high.
- R4: Going from standby to drive with no power-save visit since the last completed precharge enters drive at once, without a precharge interval.
- R5: Test mode (level 3) raises the test force output and grants both bank permissions.
- R6: A low on the external fault input or on the overtemperature input drives all three gate controls low without changing the operating mode. When the input returns high, drive resumes without a precharge.
- R7: While undervoltage is high, all gate controls are low and the Hall bias stays on. When it clears, the block re-enters through standby and then follows the level input.
- R8: In drive with stall detection enabled, a Hall code held for STALL_CYC cycles sets the stall output and removes the high-side permission, while the low-side permission stays high.
- R9: Any change of the Hall code restarts the stall count, so Hall changes spaced closer than STALL_CYC cycles never trip the stall guard.
- R10: A tripped stall guard clears by itself STALL_CYC cycles after it trips.
- R11: Level 0 clears a tripped stall guard and resets its count.
- R12: While thermal shutdown is high, the stall count is frozen. Counting resumes from the frozen value once it falls.
- R13: With stall detection disabled, the stall output stays low however long the Hall code is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_i | input | 2 | Control level: 0 power-save, 1 standby, 2 drive, 3 test |
| fault_n_i | input | 1 | External fault, active low |
| ot_n_i | input | 1 | Overtemperature sense, active low |
| tsd_i | input | 1 | Thermal shutdown flag, freezes the stall count |
| uv_i | input | 1 | Undervoltage flag |
| stall_en_i | input | 1 | Enables stall detection |
| hall_i | input | 3 | Hall sensor code |
| hs_allow_o | output | 1 | High-side gates may follow commutation |
| ls_allow_o | output | 1 | Low-side gates may follow commutation |
| ls_force_o | output | 1 | Low-side gates forced on for bootstrap charging |
| hall_bias_o | output | 1 | Hall sensor bias supply enable |
| speed_hold_o | output | 1 | Holds the speed pulse outputs high |
| test_force_o | output | 1 | Forces 120-degree conduction at maximum duty |
| stall_o | output | 1 | Stall guard tripped |

## Verification
The hardest state to reach from the ports is a stall count that thermal shutdown has frozen partway through. The stimulus therefore enters drive from power-save so the count starts at zero, and it holds the Hall code steady for a known number of cycles. It then raises thermal shutdown for longer than a full stall period and checks that no trip occurs. After the flag falls, it samples just before and just after the remaining count would expire. The exact precharge length is measured in the same way: the level moves to drive only right after a standby charge pulse has ended, so that the precharge run stands apart from the pulse.

// File: rtl/motor_sup_pkg.sv
package motor_sup_pkg;
  typedef enum logic [1:0] {
    LVL_SAVE  = 2'd0,
    LVL_STBY  = 2'd1,
    LVL_DRIVE = 2'd2,
    LVL_TEST  = 2'd3
  } level_e;

  typedef enum logic [2:0] {
    ST_SAVE,
    ST_STBY,
    ST_BOOT,
    ST_RUN,
    ST_TEST,
    ST_UVLO
  } mode_e;
endpackage

// File: rtl/sup_mode_fsm.sv
module sup_mode_fsm
  import motor_sup_pkg::*;
#(
  parameter int BOOT_CYC     = 960000,
  parameter int PULSE_W      = 500,
  parameter int PULSE_PERIOD = 25000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] level_i,
  input  logic       uv_i,
  output mode_e      mode_o,
  output logic       pulse_o
);
  localparam int TMAX = (BOOT_CYC > PULSE_PERIOD) ? BOOT_CYC : PULSE_PERIOD;
  localparam int TW   = $clog2(TMAX + 1);

  mode_e          state_q, state_d;
  logic [TW-1:0]  tmr_q;
  logic           armed_q;
  logic           boot_done;

  assign boot_done = (tmr_q == TW'(BOOT_CYC - 1));

  always_comb begin
    state_d = state_q;
    if (uv_i) begin
      state_d = ST_UVLO;
    end else begin
      case (state_q)
        ST_SAVE: if (level_i != LVL_SAVE) state_d = ST_STBY;
        ST_STBY: begin
          if (level_i == LVL_SAVE)       state_d = ST_SAVE;
          else if (level_i == LVL_DRIVE) state_d = armed_q ? ST_BOOT : ST_RUN;
          else if (level_i == LVL_TEST)  state_d = ST_TEST;
        end
        ST_BOOT: begin
          if (level_i == LVL_SAVE)      state_d = ST_SAVE;
          else if (level_i == LVL_STBY) state_d = ST_STBY;
          else if (boot_done)           state_d = (level_i == LVL_TEST) ? ST_TEST : ST_RUN;
        end
        ST_RUN, ST_TEST: begin
          if (level_i == LVL_SAVE)       state_d = ST_SAVE;
          else if (level_i == LVL_STBY)  state_d = ST_STBY;
          else if (level_i == LVL_TEST)  state_d = ST_TEST;
          else                           state_d = ST_RUN;
        end
        default: state_d = ST_STBY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SAVE;
      tmr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        tmr_q <= '0;
      else if (state_q == ST_BOOT)
        tmr_q <= tmr_q + 1'b1;
      else if (state_q == ST_STBY)
        tmr_q <= (tmr_q == TW'(PULSE_PERIOD - 1)) ? '0 : tmr_q + 1'b1;
      else
        tmr_q <= '0;
      if (state_q == ST_SAVE && state_d == ST_STBY)
        armed_q <= 1'b1;
      else if (state_q == ST_BOOT && (state_d == ST_RUN || state_d == ST_TEST))
        armed_q <= 1'b0;
    end
  end

  assign mode_o  = state_q;
  assign pulse_o = (state_q == ST_STBY) && (tmr_q < TW'(PULSE_W));

  // R3
  boot_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BOOT) |-> armed_q);

  // R4
  direct_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STBY && !armed_q && !uv_i && level_i == LVL_DRIVE) |=> (state_q == ST_RUN));

  // R7
  uv_lock_chk: assert property (@(posedge clk) disable iff (rst)
    uv_i |=> (state_q == ST_UVLO));
endmodule

// File: rtl/sup_stall_timer.sv
module sup_stall_timer
  import motor_sup_pkg::*;
#(
  parameter int STALL_CYC = 500000000
) (
  input  logic       clk,
  input  logic       rst,
  input  mode_e      mode_i,
  input  logic       en_i,
  input  logic       tsd_i,
  input  logic [2:0] hall_i,
  output logic       stall_o
);
  localparam int CW = $clog2(STALL_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          trip_q;
  logic [2:0]    hall_q;
  logic          hall_moved, driving, at_limit;

  assign hall_moved = (hall_i != hall_q);
  assign driving    = (mode_i == ST_RUN) || (mode_i == ST_TEST);
  assign at_limit   = (cnt_q == CW'(STALL_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
      hall_q <= '0;
    end else begin
      hall_q <= hall_i;
      if (mode_i == ST_SAVE || !en_i) begin
        cnt_q  <= '0;
        trip_q <= 1'b0;
      end else if (tsd_i) begin
        cnt_q  <= cnt_q;
      end else if (trip_q) begin
        if (at_limit) begin
          trip_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end else if (hall_moved) begin
        cnt_q  <= '0;
      end else if (driving) begin
        if (at_limit) begin
          trip_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign stall_o = trip_q;

  // R11
  save_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == ST_SAVE) |=> (!trip_q && cnt_q == '0));

  // R12
  tsd_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (tsd_i && en_i && mode_i != ST_SAVE) |=> ($stable(cnt_q) && $stable(trip_q)));

  // R13
  disable_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !trip_q);
endmodule

// File: rtl/sup_out_stage.sv
module sup_out_stage
  import motor_sup_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_i,
  input  logic  pulse_i,
  input  logic  stall_i,
  input  logic  fault_n_i,
  input  logic  ot_n_i,
  output logic  hs_allow_o,
  output logic  ls_allow_o,
  output logic  ls_force_o,
  output logic  hall_bias_o,
  output logic  speed_hold_o,
  output logic  test_force_o
);
  logic gate_ok, hs_d, ls_d, force_d;

  assign gate_ok = fault_n_i && ot_n_i;

  always_comb begin
    hs_d    = 1'b0;
    ls_d    = 1'b0;
    force_d = 1'b0;
    case (mode_i)
      ST_STBY: force_d = pulse_i;
      ST_BOOT: force_d = 1'b1;
      ST_RUN, ST_TEST: begin
        hs_d = !stall_i;
        ls_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_allow_o   <= 1'b0;
      ls_allow_o   <= 1'b0;
      ls_force_o   <= 1'b0;
      hall_bias_o  <= 1'b0;
      speed_hold_o <= 1'b1;
      test_force_o <= 1'b0;
    end else begin
      hs_allow_o   <= gate_ok && hs_d;
      ls_allow_o   <= gate_ok && ls_d;
      ls_force_o   <= gate_ok && force_d;
      hall_bias_o  <= (mode_i != ST_SAVE);
      speed_hold_o <= (mode_i == ST_SAVE);
      test_force_o <= (mode_i == ST_TEST);
    end
  end

  // R1
  save_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == ST_SAVE) |=> (!hall_bias_o && speed_hold_o && !hs_allow_o && !ls_allow_o && !ls_force_o));

  // R6
  fault_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_n_i || !ot_n_i) |=> (!hs_allow_o && !ls_allow_o && !ls_force_o));

  // R8
  stall_hs_chk: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> !hs_allow_o);

  // R5
  test_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == ST_TEST) |=> test_force_o);
endmodule

// File: rtl/motor_mode_supervisor.sv
module motor_mode_supervisor
  import motor_sup_pkg::*;
#(
  parameter int BOOT_CYC     = 960000,
  parameter int PULSE_W      = 500,
  parameter int PULSE_PERIOD = 25000,
  parameter int STALL_CYC    = 500000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] level_i,
  input  logic       fault_n_i,
  input  logic       ot_n_i,
  input  logic       tsd_i,
  input  logic       uv_i,
  input  logic       stall_en_i,
  input  logic [2:0] hall_i,
  output logic       hs_allow_o,
  output logic       ls_allow_o,
  output logic       ls_force_o,
  output logic       hall_bias_o,
  output logic       speed_hold_o,
  output logic       test_force_o,
  output logic       stall_o
);
  mode_e mode;
  logic  pulse;
  logic  stall;

  sup_mode_fsm #(
    .BOOT_CYC    (BOOT_CYC),
    .PULSE_W     (PULSE_W),
    .PULSE_PERIOD(PULSE_PERIOD)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .level_i (level_i),
    .uv_i    (uv_i),
    .mode_o  (mode),
    .pulse_o (pulse)
  );

  sup_stall_timer #(
    .STALL_CYC(STALL_CYC)
  ) u_stall (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode),
    .en_i    (stall_en_i),
    .tsd_i   (tsd_i),
    .hall_i  (hall_i),
    .stall_o (stall)
  );

  sup_out_stage u_out (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode),
    .pulse_i      (pulse),
    .stall_i      (stall),
    .fault_n_i    (fault_n_i),
    .ot_n_i       (ot_n_i),
    .hs_allow_o   (hs_allow_o),
    .ls_allow_o   (ls_allow_o),
    .ls_force_o   (ls_force_o),
    .hall_bias_o  (hall_bias_o),
    .speed_hold_o (speed_hold_o),
    .test_force_o (test_force_o)
  );

  assign stall_o = stall;
endmodule

// File: tb/motor_mode_supervisor_bench.sv
module motor_mode_supervisor_bench;
  localparam int BOOT  = 20;
  localparam int PW    = 3;
  localparam int PER   = 10;
  localparam int STALL = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] level_i = 2'd0;
  logic       fault_n_i = 1'b1, ot_n_i = 1'b1, tsd_i = 1'b0, uv_i = 1'b0;
  logic       stall_en_i = 1'b0;
  logic [2:0] hall_i = 3'b101;
  logic       hs_allow_o, ls_allow_o, ls_force_o, hall_bias_o, speed_hold_o, test_force_o, stall_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  motor_mode_supervisor #(
    .BOOT_CYC(BOOT), .PULSE_W(PW), .PULSE_PERIOD(PER), .STALL_CYC(STALL)
  ) u_motor_mode_supervisor (
    .clk(clk), .rst(rst), .level_i(level_i), .fault_n_i(fault_n_i), .ot_n_i(ot_n_i),
    .tsd_i(tsd_i), .uv_i(uv_i), .stall_en_i(stall_en_i), .hall_i(hall_i),
    .hs_allow_o(hs_allow_o), .ls_allow_o(ls_allow_o), .ls_force_o(ls_force_o),
    .hall_bias_o(hall_bias_o), .speed_hold_o(speed_hold_o), .test_force_o(test_force_o),
    .stall_o(stall_o)
  );

  // entry: {level[1:0], fault_n, ot_n, uv, wait[7:0], expect{hs,la,lf,bias,hold,test}[5:0], req[3:0]}
  localparam int NVEC = 9;
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b1, 1'b0, 8'd4,  6'b000010, 4'd1},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'd30, 6'b110100, 4'd3},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'd4,  6'b110101, 4'd5},
    {2'd3, 1'b0, 1'b1, 1'b0, 8'd4,  6'b000101, 4'd6},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'd4,  6'b000100, 4'd6},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'd4,  6'b110100, 4'd6},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'd4,  6'b000100, 4'd7},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'd4,  6'b110100, 4'd7},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'd4,  6'b000010, 4'd1}
  };

  function automatic string req_name(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      13: return "R13";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [5:0] outs();
    return {hs_allow_o, ls_allow_o, ls_force_o, hall_bias_o, speed_hold_o, test_force_o};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, actual, expected, $time);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int run;
    int hits;
    bit seen;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1", outs(), 6'b000010);
    check("R1", stall_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      level_i   = VEC[i][22:21];
      fault_n_i = VEC[i][20];
      ot_n_i    = VEC[i][19];
      uv_i      = VEC[i][18];
      step(int'(VEC[i][17:10]));
      check(req_name(int'(VEC[i][3:0])), outs(), VEC[i][9:4]);
    end

    // R2 standby charge pulses
    level_i = 2'd1;
    step(5);
    hits = 0;
    seen = 1'b0;
    for (int k = 0; k < 4 * PER; k++) begin
      if (ls_force_o) hits++;
      if (hs_allow_o) seen = 1'b1;
      step(1);
    end
    check("R2", hits, 4 * PW);
    check("R2", seen, 0);

    // R3 exact precharge length after power-save -> standby -> drive
    level_i = 2'd0;
    step(4);
    level_i = 2'd1;
    step(3);
    for (int k = 0; k < 3 * PER && ls_force_o; k++) step(1);
    for (int k = 0; k < 3 * PER && !ls_force_o; k++) step(1);
    for (int k = 0; k < 3 * PER && ls_force_o; k++) step(1);
    level_i = 2'd2;
    for (int k = 0; k < 5 && !ls_force_o; k++) step(1);
    run = 0;
    seen = 1'b0;
    while (ls_force_o && run < 4 * BOOT) begin
      run++;
      if (hs_allow_o || ls_allow_o) seen = 1'b1;
      step(1);
    end
    check("R3", run, BOOT);
    check("R3", seen, 0);
    check("R3", {hs_allow_o, ls_allow_o}, 2'b11);

    // R4 standby to drive without a power-save visit: no precharge
    level_i = 2'd1;
    step(4);
    level_i = 2'd2;
    step(3);
    check("R4", {hs_allow_o, ls_allow_o, ls_force_o}, 3'b110);

    // R8 trip, R10 automatic recovery
    stall_en_i = 1'b1;
    step(STALL / 2);
    check("R8", stall_o, 0);
    step(STALL);
    check("R8", stall_o, 1);
    check("R8", {hs_allow_o, ls_allow_o}, 2'b01);
    step(30);
    check("R10", stall_o, 0);
    step(35);
    check("R10", stall_o, 1);

    // R11 power-save clears the trip
    level_i = 2'd0;
    step(3);
    check("R11", stall_o, 0);
    level_i = 2'd2;
    step(BOOT + 6);
    check("R11", stall_o, 0);

    // R9 Hall activity keeps reloading
    seen = 1'b0;
    for (int k = 0; k < 4 * STALL; k++) begin
      if (k % 10 == 0) hall_i = {hall_i[1:0], hall_i[2]};
      if (stall_o) seen = 1'b1;
      step(1);
    end
    check("R9", seen, 0);

    // R12 thermal shutdown freezes the count
    level_i = 2'd0;
    step(3);
    level_i = 2'd2;
    step(BOOT + 6);
    step(16);
    tsd_i = 1'b1;
    step(100);
    check("R12", stall_o, 0);
    tsd_i = 1'b0;
    step(12);
    check("R12", stall_o, 0);
    step(18);
    check("R12", stall_o, 1);

    // R13 stall detection disabled
    stall_en_i = 1'b0;
    step(3 * STALL);
    check("R13", stall_o, 0);
    check("R13", hs_allow_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule